// File: doc/BRIEF.md
# Serial Port Register Block

A bus-slave register file for a simple serial port in which bytes move in parallel. A processor reaches it through single-word accesses selected by a word index. A write to the data-out word sends one byte out on a valid/ready stream.

Incoming bytes arrive on a second valid/ready stream and are queued in a small receive FIFO. Software reads that queue through two status words. One of them returns the oldest byte and removes it. The other returns the same byte and leaves it in place.

A raw interrupt word records transmit events and receive-data presence. An interrupt mask selects which raw bits drive the single level interrupt output. Raw bits are cleared by writing ones to an acknowledge word.

Top module: `serport_regs`

## Requirements
- R1: After reset the following hold: the receive-control word (index 2) reads 0x00010000; the other stored words read 0; `tx_valid` and `irq` are 0; status bits 24 and 22 read 1 and status bit 16 reads 0.
- R2: Writes to the transmit-control word (index 0), transmit-DMA word (index 1), receive-control word (index 2), data-out word (index 7) and interrupt-mask word (index 11) read back exactly the 32-bit value written.
- R3: Bytes accepted on the receive stream are returned in arrival order by reads of the popping status word (index 8). Up to DEPTH bytes are held.
- R4: A byte that arrives while the FIFO holds DEPTH bytes is dropped. Occupancy and the held bytes are unchanged.
- R5: `rx_ready` equals bit 3 of the receive-control word. A byte presented while that bit is 0 is not stored.
- R6: Both status words (index 8 and index 9) have the same layout. Bits 7:0 hold the oldest held byte. Bit 16 is 1 when the FIFO is non-empty. Bits 24 and 22 always read 1. All other bits read 0.
- R7: A read of index 9 never changes occupancy. A read of index 8 removes a byte only when the FIFO is non-empty.
- R8: A write to index 7 places bits 7:0 on `tx_data` and raises `tx_valid` on the next cycle. `tx_valid` stays high until a cycle with `tx_ready` high. The write also sets raw interrupt bits 0 and 1.
- R9: A write to the acknowledge word (index 12) clears every raw interrupt bit whose written bit is 1. The written value reads back at index 12.
- R10: Raw interrupt bit 3 reads 1 exactly while the FIFO is non-empty. An acknowledge write does not clear it.
- R11: The masked interrupt word (index 14) reads raw AND mask. `irq` is high exactly when that value is nonzero.
- R12: Writes to indices 8, 9, 13 and 14 and to unassigned indices have no effect. Unassigned indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access strobe, one word per cycle |
| we | input | 1 | 1 = write, 0 = read |
| word_addr | input | AW | Word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, valid during the access cycle |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Sink accepts outgoing byte |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Receiver enabled |
| irq | output | 1 | Level interrupt, high when any masked bit is set |

## Verification
The bench builds the block with its defaults, DEPTH = 16 and AW = 4. With a 16-entry queue, the overflow-drop case is reached after a short burst of 17 bytes. The full wrap of the write pointer is reached as well. A 4-bit index covers every word, including index 15, which lies outside the decoded window.

// File: rtl/serport_regs.sv
module serport_regs #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] word_addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_valid,
  output logic          rx_ready
  ,output logic         irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [AW-1:0] IX_TXC = AW'(0), IX_DMA = AW'(1), IX_RXC = AW'(2),
    IX_DOUT = AW'(7), IX_POP = AW'(8), IX_PEEK = AW'(9), IX_MASK = AW'(11),
    IX_ACK = AW'(12), IX_RAW = AW'(13), IX_MSKD = AW'(14);
  localparam int RX_EN = 3;
  localparam logic [31:0] RXC_RST = 32'h0001_0000;

  logic [31:0] txc_q, dma_q, rxc_q, dout_q, mask_q, ack_q, raw_q;
  logic [7:0]  mem [DEPTH];
  logic [PW-1:0] wp;
  logic [PW:0]   cnt;

  wire wr       = req && we;
  wire rd       = req && !we;
  wire nonempty = cnt != '0;
  wire push     = rx_valid && rx_ready && (cnt != (PW+1)'(DEPTH));
  wire pop      = rd && word_addr == IX_POP && nonempty;
  wire [PW-1:0] rp = wp - cnt[PW-1:0];
  wire [7:0]  oldest   = mem[rp];
  wire [31:0] raw_view = {raw_q[31:4], nonempty, raw_q[2:0]};
  wire [31:0] masked   = raw_view & mask_q;
  wire [31:0] status   = {7'b0, 1'b1, 1'b0, 1'b1, 5'b0, nonempty, 8'b0, oldest};

  assign rx_ready = rxc_q[RX_EN];
  assign irq      = |masked;

  always_comb begin
    case (word_addr)
      IX_TXC:           rdata = txc_q;
      IX_DMA:           rdata = dma_q;
      IX_RXC:           rdata = rxc_q;
      IX_DOUT:          rdata = dout_q;
      IX_POP, IX_PEEK:  rdata = status;
      IX_MASK:          rdata = mask_q;
      IX_ACK:           rdata = ack_q;
      IX_RAW:           rdata = raw_view;
      IX_MSKD:          rdata = masked;
      default:          rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txc_q <= '0; dma_q <= '0; rxc_q <= RXC_RST; dout_q <= '0;
      mask_q <= '0; ack_q <= '0; raw_q <= '0;
      tx_valid <= 1'b0; tx_data <= '0;
    end else begin
      if (wr && word_addr == IX_TXC)  txc_q  <= wdata;
      if (wr && word_addr == IX_DMA)  dma_q  <= wdata;
      if (wr && word_addr == IX_RXC)  rxc_q  <= wdata;
      if (wr && word_addr == IX_MASK) mask_q <= wdata;
      if (wr && word_addr == IX_DOUT) begin
        dout_q   <= wdata;
        tx_data  <= wdata[7:0];
        tx_valid <= 1'b1;
        raw_q    <= raw_q | 32'h3;
      end else begin
        if (tx_ready) tx_valid <= 1'b0;
        if (wr && word_addr == IX_ACK) begin
          ack_q <= wdata;
          raw_q <= raw_q & ~wdata;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) if (push) mem[wp] <= rx_data;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (PW+1)'(DEPTH));
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && cnt == (PW+1)'(DEPTH) && !pop) |=> ($stable(cnt) && $stable(wp)));
  assert_rx_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rxc_q[RX_EN] && !pop) |=> $stable(cnt));
  assert_peek_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && word_addr == IX_PEEK && !push) |=> $stable(cnt));
  assert_tx_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word_addr == IX_DOUT) |=> (tx_valid && raw_q[1:0] == 2'b11));
  assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(wr && word_addr == IX_DOUT)) |=> (tx_valid && $stable(tx_data)));
  assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word_addr == IX_ACK && wdata[1:0] == 2'b11) |=> raw_q[1:0] == 2'b00);
endmodule

// File: tb/serport_regs_tb.sv
module serport_regs_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0;
  logic [3:0] word_addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, irq;
  int n_run = 0, n_fail = 0;
  logic [31:0] rd;

  serport_regs u_dut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .word_addr(word_addr),
    .wdata(wdata), .rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq));

  always #10 clk = ~clk;

  // {we, word index, write data, expected read data}
  localparam int NV = 18;
  localparam logic [68:0] VEC [NV] = '{
    {1'b1, 4'd0,  32'h1234_5678, 32'h0}, {1'b0, 4'd0,  32'h0, 32'h1234_5678},
    {1'b1, 4'd1,  32'h0000_0001, 32'h0}, {1'b0, 4'd1,  32'h0, 32'h0000_0001},
    {1'b1, 4'd2,  32'h0001_0008, 32'h0}, {1'b0, 4'd2,  32'h0, 32'h0001_0008},
    {1'b1, 4'd11, 32'h0000_000B, 32'h0}, {1'b0, 4'd11, 32'h0, 32'h0000_000B},
    {1'b1, 4'd12, 32'h0000_0000, 32'h0}, {1'b0, 4'd12, 32'h0, 32'h0000_0000},
    {1'b1, 4'd13, 32'hFFFF_FFFF, 32'h0}, {1'b0, 4'd13, 32'h0, 32'h0000_0000},
    {1'b1, 4'd5,  32'hAAAA_5555, 32'h0}, {1'b0, 4'd5,  32'h0, 32'h0000_0000},
    {1'b1, 4'd14, 32'hFFFF_FFFF, 32'h0}, {1'b0, 4'd14, 32'h0, 32'h0000_0000},
    {1'b1, 4'd15, 32'h1357_9BDF, 32'h0}, {1'b0, 4'd15, 32'h0, 32'h0000_0000}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; word_addr = a; wdata = d;
    #1 rd = rdata;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(posedge clk); #1 rx_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    acc(0, 4'd2, 0);  chk("R1 rxctl", rd, 32'h0001_0000);
    acc(0, 4'd11, 0); chk("R1 mask", rd, 32'h0);
    acc(0, 4'd13, 0); chk("R1 raw", rd, 32'h0);
    acc(0, 4'd9, 0);  chk("R1 status", {rd[31:8], 8'h0}, 32'h0140_0000);
    chk("R1 tx_valid/irq", {30'b0, tx_valid, irq}, 32'h0);
    chk("R5 ready off", {31'b0, rx_ready}, 32'h0);

    // R2 R9 R11 R12 table walk
    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][68], VEC[i][67:64], VEC[i][63:32]);
      if (!VEC[i][68]) chk("R2/R12 table", rd, VEC[i][31:0]);
    end
    chk("R5 ready on", {31'b0, rx_ready}, 32'h1);

    // R8 transmit
    acc(1, 4'd7, 32'h1234_56A5);
    @(negedge clk);
    chk("R8 tx valid/data", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'hA5});
    repeat (2) @(negedge clk);
    chk("R8 tx hold", {23'b0, tx_valid, tx_data}, {23'b0, 1'b1, 8'hA5});
    tx_ready = 1; @(posedge clk); #1 tx_ready = 0;
    chk("R8 tx done", {31'b0, tx_valid}, 32'h0);
    acc(0, 4'd7, 0);  chk("R2 dout readback", rd, 32'h1234_56A5);
    acc(0, 4'd13, 0); chk("R8 raw bits", rd, 32'h3);
    acc(0, 4'd14, 0); chk("R11 masked", rd, 32'h3);
    chk("R11 irq high", {31'b0, irq}, 32'h1);

    // R9 ack
    acc(1, 4'd12, 32'h1);
    acc(0, 4'd13, 0); chk("R9 ack bit0", rd, 32'h2);
    acc(0, 4'd12, 0); chk("R9 ack stored", rd, 32'h1);
    chk("R11 irq still", {31'b0, irq}, 32'h1);
    acc(1, 4'd12, 32'h2);
    @(negedge clk); chk("R11 irq low", {31'b0, irq}, 32'h0);

    // R3 R4 fill beyond full
    for (int i = 0; i < 17; i++) push(8'h40 + 8'(i));
    acc(0, 4'd9, 0); chk("R6 peek status", rd, 32'h0141_0040);
    acc(0, 4'd9, 0); chk("R7 peek keeps", rd, 32'h0141_0040);
    acc(0, 4'd13, 0); chk("R10 raw bit3", rd, 32'h8);
    acc(1, 4'd12, 32'h8);
    acc(0, 4'd13, 0); chk("R10 ack no clear", rd, 32'h8);
    acc(1, 4'd11, 32'h8);
    @(negedge clk); chk("R11 irq on data", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      acc(0, 4'd8, 0);
      chk("R3/R4 pop order", {rd[16], rd[7:0]}, {1'b1, 8'h40 + 8'(i)});
    end
    acc(0, 4'd9, 0); chk("R4 drop/empty", {rd[31:8], 8'h0}, 32'h0140_0000);
    acc(0, 4'd13, 0); chk("R10 raw empty", rd, 32'h0);
    chk("R11 irq off", {31'b0, irq}, 32'h0);

    // R7 pop on empty
    acc(0, 4'd8, 0);
    push(8'h77);
    acc(0, 4'd8, 0); chk("R7 empty pop no effect", {rd[16], rd[7:0]}, {1'b1, 8'h77});
    acc(0, 4'd9, 0); chk("R7 pop removed", {31'b0, rd[16]}, 32'h0);

    // R5 disabled receiver, R12 writes to status words
    acc(1, 4'd2, 32'h0);
    chk("R5 ready cleared", {31'b0, rx_ready}, 32'h0);
    push(8'h55);
    acc(1, 4'd8, 32'hFFFF_FFFF);
    acc(1, 4'd9, 32'hFFFF_FFFF);
    acc(0, 4'd9, 0); chk("R5/R12 nothing stored", {rd[31:8], 8'h0}, 32'h0140_0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule